// File: doc/BRIEF.md
# Fixed-Head Disk Controller Command and Status Register

This block owns the 18-bit function/status word of a fixed-head disk controller and turns each processor I/O instruction into register actions. An instruction arrives as a 6-bit pulse code together with the 18-bit accumulator. Bits 0, 1 and 2 of the code each select an action group, and bits 5:4 form a subcode. The block hands back the accumulator with any read data ORed in, plus a skip flag.

The transfer sequencer reports error and completion events on dedicated inputs. The block folds these into the status word and keeps four things consistent: the error summary, done, busy and the interrupt request. It emits one-cycle start and cancel strobes to the sequencer. It also emits load strobes, with their values, for the disk-address, word-count and memory-address registers. Those registers live in neighbouring blocks, as do data movement, address conversion and rotational timing.

Within one instruction the three action groups take effect in the order bit 0, bit 1, bit 2. Sequencer events that arrive in the same cycle apply after the instruction.

Top module: `dskctl_csr`

## Requirements
- R1: A synchronous reset clears the status word, the interrupt request and the start, cancel and load strobes.
- R2: Pulse bit 1 with subcode 01 ORs the status word into `ac_out`. Bit 17 is the error summary, 16 parity, 15 illegal address, 14 timing, 13 not ready, 12 done, 11 interrupt enable, 10 busy and 9 write direction. Bits 8..0 always read zero.
- R3: Pulse bit 1 with subcode 00 ORs the zero-extended `da_bcd` input into `ac_out`.
- R4: Pulse bit 2 with subcode 10 loads status as (old AND bits 11,10,9) XOR (AC with bits 8..0 cleared).
- R5: The error summary bit always equals the OR of bits 16..13.
- R6: Whenever done is set, busy reads zero, including when a load sets both.
- R7: `irq` is high exactly while (summary OR done) AND interrupt enable. It follows the status word in the same cycle.
- R8: Pulse bit 0 with subcode 00 clears bits 17..12 and leaves bits 11..9 unchanged.
- R9: Pulse bit 0 with subcode 01 drives `skip` high in that cycle if the summary or done bit is set. Otherwise `skip` is low.
- R10: Pulse bit 0 with subcode 10 clears the whole status word. This happens before any status load in the same instruction.
- R11: In the cycle after the instruction, a one-cycle strobe with its value is issued for each of these loads. Bit 2 subcode 00 loads the disk address with AC. Bit 2 subcode 01 loads the word count with AC[15:0]. Bit 1 subcode 10 loads the memory address with AC[14:0].
- R12: In the cycle after a status load, `start` pulses if busy is set after the load and `xfer_active` is low. `cancel` pulses if busy is clear after the load.
- R13: The event inputs set their flag bits (parity 16, illegal 15, timing 14, not ready 13, done 12). They apply after any instruction in the same cycle.
- R14: Subcode 11 performs no action on any pulse bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iot_valid | input | 1 | Instruction present this cycle |
| iot_pulse | input | 6 | Pulse code: bits 0..2 action groups, bits 5:4 subcode |
| iot_ac | input | 18 | Accumulator value |
| ac_out | output | 18 | Accumulator with read data ORed in |
| skip | output | 1 | Skip-condition result |
| da_bcd | input | 17 | Current disk address in BCD form |
| evt_par | input | 1 | Parity error event |
| evt_ila | input | 1 | Illegal address event |
| evt_tim | input | 1 | Timing error event |
| evt_nry | input | 1 | Not ready event |
| evt_done | input | 1 | Transfer complete event |
| xfer_active | input | 1 | Sequencer has a transfer in progress |
| irq | output | 1 | Interrupt request |
| start | output | 1 | Start strobe to sequencer |
| cancel | output | 1 | Cancel strobe to sequencer |
| da_ld | output | 1 | Disk-address load strobe |
| da_ld_val | output | 18 | Disk-address load value |
| wc_ld | output | 1 | Word-count load strobe |
| wc_ld_val | output | 16 | Word-count load value |
| ma_ld | output | 1 | Memory-address load strobe |
| ma_ld_val | output | 15 | Memory-address load value |

## Verification
A corrupted status bit shows at `irq` on the next clock edge if it touches enable, summary or done. It shows on `ac_out` at the next status read, and on `skip` at the next skip test. A wrong busy value shows as a misplaced `start` or `cancel` one cycle after the next status load. The XOR load makes any stale interrupt-enable, busy or direction bit propagate into every later load rather than being overwritten. Random instruction and event streams compare every read, skip and strobe against a model, so a divergence surfaces within a few instructions.

// File: rtl/dskctl_pkg.sv
package dskctl_pkg;
   localparam int STS_W   = 18;
   localparam int B_ERR   = 17;
   localparam int B_PAR   = 16;
   localparam int B_ILA   = 15;
   localparam int B_TIM   = 14;
   localparam int B_NRY   = 13;
   localparam int B_DONE  = 12;
   localparam int B_IE    = 11;
   localparam int B_BUSY  = 10;
   localparam int B_WR    = 9;
   localparam int FLAG_LO = B_NRY;
   localparam int FLAG_HI = B_PAR;
   localparam int N_FLAGS = FLAG_HI - FLAG_LO + 1;
   localparam int HELD_W  = STS_W - B_WR;

   typedef enum logic [1:0] {
      SC_A    = 2'b00,
      SC_B    = 2'b01,
      SC_C    = 2'b10,
      SC_NONE = 2'b11
   } subcode_e;

   typedef struct packed {
      logic clr_flags;
      logic test_skip;
      logic clr_all;
      logic rd_da;
      logic rd_sts;
      logic ld_ma;
      logic ld_da;
      logic ld_wc;
      logic ld_sts;
   } iot_act_t;
endpackage

// File: rtl/dskctl_decode.sv
module dskctl_decode
   import dskctl_pkg::*;
#(
   parameter int PULSE_W = 6
)(
   input  logic               valid,
   input  logic [PULSE_W-1:0] pulse,
   output iot_act_t           act
);
   subcode_e sc;
   logic     unused_pulse_bits;

   assign sc                = subcode_e'(pulse[5:4]);
   assign unused_pulse_bits = pulse[3];

   always_comb begin
      act = '0;
      if (valid) begin
         if (pulse[0]) begin
            case (sc)
               SC_A:    act.clr_flags = 1'b1;
               SC_B:    act.test_skip = 1'b1;
               SC_C:    act.clr_all   = 1'b1;
               default: ;
            endcase
         end
         if (pulse[1]) begin
            case (sc)
               SC_A:    act.rd_da  = 1'b1;
               SC_B:    act.rd_sts = 1'b1;
               SC_C:    act.ld_ma  = 1'b1;
               default: ;
            endcase
         end
         if (pulse[2]) begin
            case (sc)
               SC_A:    act.ld_da  = 1'b1;
               SC_B:    act.ld_wc  = 1'b1;
               SC_C:    act.ld_sts = 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dskctl_status.sv
module dskctl_status
   import dskctl_pkg::*;
#(
   parameter int NFLAG = 4
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clr_flags,
   input  logic                  clr_all,
   input  logic                  ld_sts,
   input  logic [STS_W-1:B_WR]   ld_word,
   input  logic [NFLAG-1:0]      err_evt,
   input  logic                  done_evt,
   output logic [STS_W-1:0]      sts,
   output logic                  iot_busy,
   output logic                  irq
);
   localparam logic [HELD_W-1:0] KEEP_MASK =
      HELD_W'((1 << (B_IE - B_WR)) | (1 << (B_BUSY - B_WR)) | 1);

   logic [STS_W-1:B_WR] sts_q;
   logic [STS_W-1:B_WR] w_pre;
   logic [STS_W-1:B_WR] w_iot;
   logic [STS_W-1:B_WR] w_nxt;
   logic [STS_W-1:B_WR] evt_word;

   function automatic logic [STS_W-1:B_WR] settle(input logic [STS_W-1:B_WR] w);
      logic [STS_W-1:B_WR] r;
      r        = w;
      r[B_ERR] = |w[FLAG_HI:FLAG_LO];
      if (r[B_DONE]) r[B_BUSY] = 1'b0;
      return r;
   endfunction

   assign evt_word[B_ERR]  = 1'b0;
   assign evt_word[B_DONE] = done_evt;
   assign evt_word[B_IE]   = 1'b0;
   assign evt_word[B_BUSY] = 1'b0;
   assign evt_word[B_WR]   = 1'b0;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag_map
      assign evt_word[FLAG_LO+i] = err_evt[i];
   end

   always_comb begin
      w_pre = sts_q;
      if (clr_all)
         w_pre = '0;
      else if (clr_flags)
         w_pre[B_ERR:B_DONE] = '0;
      if (ld_sts)
         w_pre = (w_pre & KEEP_MASK) ^ ld_word;
      w_iot = settle(w_pre);
      w_nxt = settle(w_iot | evt_word);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sts_q <= '0;
         irq   <= 1'b0;
      end else begin
         sts_q <= w_nxt;
         irq   <= (w_nxt[B_ERR] | w_nxt[B_DONE]) & w_nxt[B_IE];
      end
   end

   assign sts      = {sts_q, {B_WR{1'b0}}};
   assign iot_busy = w_iot[B_BUSY];
endmodule

// File: rtl/dskctl_strobe.sv
module dskctl_strobe #(
   parameter int AC_W = 18,
   parameter int WC_W = 16,
   parameter int MA_W = 15
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            ld_sts,
   input  logic            ld_da,
   input  logic            ld_wc,
   input  logic            ld_ma,
   input  logic [AC_W-1:0] ac,
   input  logic            iot_busy,
   input  logic            xfer_active,
   output logic            start,
   output logic            cancel,
   output logic            da_ld,
   output logic [AC_W-1:0] da_ld_val,
   output logic            wc_ld,
   output logic [WC_W-1:0] wc_ld_val,
   output logic            ma_ld,
   output logic [MA_W-1:0] ma_ld_val
);
   always_ff @(posedge clk) begin
      if (rst) begin
         start  <= 1'b0;
         cancel <= 1'b0;
         da_ld  <= 1'b0;
         wc_ld  <= 1'b0;
         ma_ld  <= 1'b0;
      end else begin
         start  <= ld_sts & iot_busy & ~xfer_active;
         cancel <= ld_sts & ~iot_busy;
         da_ld  <= ld_da;
         wc_ld  <= ld_wc;
         ma_ld  <= ld_ma;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         da_ld_val <= '0;
         wc_ld_val <= '0;
         ma_ld_val <= '0;
      end else begin
         if (ld_da) da_ld_val <= ac;
         if (ld_wc) wc_ld_val <= ac[WC_W-1:0];
         if (ld_ma) ma_ld_val <= ac[MA_W-1:0];
      end
   end
endmodule

// File: rtl/dskctl_csr.sv
module dskctl_csr
   import dskctl_pkg::*;
#(
   parameter int PULSE_W = 6,
   parameter int AC_W    = 18,
   parameter int DA_W    = 17,
   parameter int WC_W    = 16,
   parameter int MA_W    = 15
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               iot_valid,
   input  logic [PULSE_W-1:0] iot_pulse,
   input  logic [AC_W-1:0]    iot_ac,
   output logic [AC_W-1:0]    ac_out,
   output logic               skip,
   input  logic [DA_W-1:0]    da_bcd,
   input  logic               evt_par,
   input  logic               evt_ila,
   input  logic               evt_tim,
   input  logic               evt_nry,
   input  logic               evt_done,
   input  logic               xfer_active,
   output logic               irq,
   output logic               start,
   output logic               cancel,
   output logic               da_ld,
   output logic [AC_W-1:0]    da_ld_val,
   output logic               wc_ld,
   output logic [WC_W-1:0]    wc_ld_val,
   output logic               ma_ld,
   output logic [MA_W-1:0]    ma_ld_val
);
   if (PULSE_W != 6) begin : g_bad_pulse
      $error("PULSE_W must be 6");
   end
   if (AC_W != STS_W) begin : g_bad_ac
      $error("AC_W must equal the status width");
   end
   if (DA_W < 1 || DA_W > AC_W) begin : g_bad_da
      $error("DA_W out of range");
   end
   if (WC_W < 1 || WC_W > AC_W) begin : g_bad_wc
      $error("WC_W out of range");
   end
   if (MA_W < 1 || MA_W > AC_W) begin : g_bad_ma
      $error("MA_W out of range");
   end

   iot_act_t            act;
   logic [STS_W-1:0]    sts_word;
   logic                iot_busy;
   logic [AC_W-1:0]     da_ext;
   logic [N_FLAGS-1:0]  err_evt;

   assign err_evt = {evt_par, evt_ila, evt_tim, evt_nry};

   if (DA_W < AC_W) begin : g_da_pad
      assign da_ext = {{(AC_W-DA_W){1'b0}}, da_bcd};
   end else begin : g_da_full
      assign da_ext = da_bcd;
   end

   dskctl_decode #(.PULSE_W(PULSE_W)) u_decode (
      .valid (iot_valid),
      .pulse (iot_pulse),
      .act   (act)
   );

   dskctl_status #(.NFLAG(N_FLAGS)) u_status (
      .clk       (clk),
      .rst       (rst),
      .clr_flags (act.clr_flags),
      .clr_all   (act.clr_all),
      .ld_sts    (act.ld_sts),
      .ld_word   (iot_ac[STS_W-1:B_WR]),
      .err_evt   (err_evt),
      .done_evt  (evt_done),
      .sts       (sts_word),
      .iot_busy  (iot_busy),
      .irq       (irq)
   );

   dskctl_strobe #(.AC_W(AC_W), .WC_W(WC_W), .MA_W(MA_W)) u_strobe (
      .clk         (clk),
      .rst         (rst),
      .ld_sts      (act.ld_sts),
      .ld_da       (act.ld_da),
      .ld_wc       (act.ld_wc),
      .ld_ma       (act.ld_ma),
      .ac          (iot_ac),
      .iot_busy    (iot_busy),
      .xfer_active (xfer_active),
      .start       (start),
      .cancel      (cancel),
      .da_ld       (da_ld),
      .da_ld_val   (da_ld_val),
      .wc_ld       (wc_ld),
      .wc_ld_val   (wc_ld_val),
      .ma_ld       (ma_ld),
      .ma_ld_val   (ma_ld_val)
   );

   always_comb begin
      ac_out = iot_ac;
      if (act.rd_da)  ac_out = ac_out | da_ext;
      if (act.rd_sts) ac_out = ac_out | sts_word;
   end

   assign skip = act.test_skip & (sts_word[B_ERR] | sts_word[B_DONE]);
endmodule

// File: rtl/dskctl_csr_chk.sv
module dskctl_csr_chk (
   input logic        clk,
   input logic        rst,
   input logic        iot_valid,
   input logic [5:0]  iot_pulse,
   input logic        evt_any,
   input logic        skip,
   input logic        irq,
   input logic        start,
   input logic        cancel,
   input logic [17:0] sts
);
   AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!irq && !start && !cancel && sts == 18'h0)); // R1
   AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst)
      sts[17] == (|sts[16:13])); // R5
   AST_DONE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
      !(sts[12] && sts[10])); // R6
   AST_IRQ_RULE: assert property (@(posedge clk) disable iff (rst)
      irq == ((sts[17] | sts[12]) & sts[11])); // R7
   AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (rst)
      skip |-> (iot_valid && iot_pulse[0] && iot_pulse[5:4] == 2'b01)); // R9
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
      (iot_valid && iot_pulse[0] && iot_pulse[5:4] == 2'b10 && !iot_pulse[2] && !evt_any)
      |=> (sts == 18'h0)); // R10
   AST_START_XOR_CANCEL: assert property (@(posedge clk) disable iff (rst)
      !(start && cancel)); // R12
   AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (start || cancel) |-> $past(iot_valid && iot_pulse[2] && iot_pulse[5:4] == 2'b10)); // R12
endmodule

bind dskctl_csr dskctl_csr_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .iot_valid (iot_valid),
   .iot_pulse (iot_pulse),
   .evt_any   (evt_par | evt_ila | evt_tim | evt_nry | evt_done),
   .skip      (skip),
   .irq       (irq),
   .start     (start),
   .cancel    (cancel),
   .sts       (sts_word)
);

// File: tb/dskctl_csr_test.sv
module dskctl_csr_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        iot_valid = 1'b0;
   logic [5:0]  iot_pulse = '0;
   logic [17:0] iot_ac = '0;
   logic [17:0] ac_out;
   logic        skip;
   logic [16:0] da_bcd = '0;
   logic        evt_par = 1'b0, evt_ila = 1'b0, evt_tim = 1'b0, evt_nry = 1'b0, evt_done = 1'b0;
   logic        xfer_active = 1'b0;
   logic        irq, start, cancel, da_ld, wc_ld, ma_ld;
   logic [17:0] da_ld_val;
   logic [15:0] wc_ld_val;
   logic [14:0] ma_ld_val;

   int n_chk  = 0;
   int n_fail = 0;
   logic [17:0] msts = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dskctl_csr uut (
      .clk(clk), .rst(rst), .iot_valid(iot_valid), .iot_pulse(iot_pulse), .iot_ac(iot_ac),
      .ac_out(ac_out), .skip(skip), .da_bcd(da_bcd), .evt_par(evt_par), .evt_ila(evt_ila),
      .evt_tim(evt_tim), .evt_nry(evt_nry), .evt_done(evt_done), .xfer_active(xfer_active),
      .irq(irq), .start(start), .cancel(cancel), .da_ld(da_ld), .da_ld_val(da_ld_val),
      .wc_ld(wc_ld), .wc_ld_val(wc_ld_val), .ma_ld(ma_ld), .ma_ld_val(ma_ld_val)
   );

   function automatic logic [17:0] m_settle(input logic [17:0] w);
      logic [17:0] r = w;
      r[8:0] = '0;
      r[17]  = |r[16:13];
      if (r[12]) r[10] = 1'b0;
      return r;
   endfunction

   function automatic logic [17:0] m_iot(input logic [17:0] s, input logic [5:0] p,
                                         input logic [17:0] ac);
      logic [17:0] w = s;
      if (p[0] && p[5:4] == 2'b10) w = '0;
      else if (p[0] && p[5:4] == 2'b00) w[17:12] = '0;
      if (p[2] && p[5:4] == 2'b10) w = (w & 18'h00E00) ^ {ac[17:9], 9'b0};
      return m_settle(w);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, a, e);
      end
   endtask

   // ev = {par, ila, tim, nry, done}
   task automatic op(input logic [5:0] p, input logic [17:0] ac, input logic [4:0] ev,
                     input logic xa, input logic [16:0] dbcd, input string req);
      logic [17:0] exp_ac, wi, wn;
      logic        exp_skip, ldsts;
      @(negedge clk);
      iot_valid = 1'b1; iot_pulse = p; iot_ac = ac; da_bcd = dbcd; xfer_active = xa;
      {evt_par, evt_ila, evt_tim, evt_nry, evt_done} = ev;
      #1;
      exp_ac = ac;
      if (p[1] && p[5:4] == 2'b00) exp_ac = exp_ac | {1'b0, dbcd};
      if (p[1] && p[5:4] == 2'b01) exp_ac = exp_ac | msts;
      chk(ac_out == exp_ac, req, ac_out, exp_ac);
      exp_skip = p[0] && p[5:4] == 2'b01 && (msts[17] || msts[12]);
      chk(skip == exp_skip, "R9 skip", skip, exp_skip);
      wi    = m_iot(msts, p, ac);
      wn    = m_settle(wi | {1'b0, ev, 12'b0});
      ldsts = p[2] && p[5:4] == 2'b10;
      @(posedge clk);
      #1;
      chk(irq == ((wn[17] | wn[12]) & wn[11]), "R7 irq", irq, (wn[17] | wn[12]) & wn[11]);
      chk(start == (ldsts && wi[10] && !xa), "R12 start", start, ldsts && wi[10] && !xa);
      chk(cancel == (ldsts && !wi[10]), "R12 cancel", cancel, ldsts && !wi[10]);
      chk(da_ld == (p[2] && p[5:4] == 2'b00), "R11 da_ld", da_ld, p[2] && p[5:4] == 2'b00);
      chk(wc_ld == (p[2] && p[5:4] == 2'b01), "R11 wc_ld", wc_ld, p[2] && p[5:4] == 2'b01);
      chk(ma_ld == (p[1] && p[5:4] == 2'b10), "R11 ma_ld", ma_ld, p[1] && p[5:4] == 2'b10);
      if (da_ld) chk(da_ld_val == ac, "R11 da value", da_ld_val, ac);
      if (wc_ld) chk(wc_ld_val == ac[15:0], "R11 wc value", wc_ld_val, ac[15:0]);
      if (ma_ld) chk(ma_ld_val == ac[14:0], "R11 ma value", ma_ld_val, ac[14:0]);
      msts = wn;
   endtask

   task automatic rd_sts(input string req);
      op(6'b010010, 18'h0, 5'b0, 1'b0, 17'h0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(irq == 1'b0 && start == 1'b0 && cancel == 1'b0, "R1 outputs after reset",
          {irq, start, cancel}, 0);
      chk(da_ld == 1'b0 && wc_ld == 1'b0 && ma_ld == 1'b0, "R1 strobes after reset",
          {da_ld, wc_ld, ma_ld}, 0);
      rd_sts("R1 status after reset");
      // R4: set IE, busy, write by XOR from zero; start expected
      op(6'b100100, 18'h00E00, 5'b0, 1'b0, 17'h0, "R4 load");
      rd_sts("R4 status IE busy wr");
      // R4: toggle busy off -> cancel
      op(6'b100100, 18'h00400, 5'b0, 1'b0, 17'h0, "R4 toggle");
      rd_sts("R4 status after toggle");
      // R6: load with done and busy together
      op(6'b100100, 18'h01400, 5'b0, 1'b0, 17'h0, "R6 load");
      rd_sts("R6 done drops busy");
      // R13/R5: parity event sets summary, irq with IE
      op(6'b000000, 18'h0, 5'b10000, 1'b0, 17'h0, "R13 event");
      rd_sts("R5 summary after parity");
      // R8: clear flags keeps IE and write
      op(6'b000001, 18'h0, 5'b0, 1'b0, 17'h0, "R8 clear flags");
      rd_sts("R8 status after clear");
      // R9: skip on done, then no skip
      op(6'b000000, 18'h0, 5'b00001, 1'b0, 17'h0, "R13 done event");
      op(6'b010001, 18'h0, 5'b0, 1'b0, 17'h0, "R9 skip set");
      op(6'b000001, 18'h0, 5'b0, 1'b0, 17'h0, "R8 clear");
      op(6'b010001, 18'h0, 5'b0, 1'b0, 17'h0, "R9 skip clear");
      // R14: subcode 11 does nothing
      op(6'b111111, 18'h3FFFF, 5'b0, 1'b0, 17'h1ABCD, "R14 no action");
      rd_sts("R14 status unchanged");
      // R10: clear all, then clear all with simultaneous done event
      op(6'b100001, 18'h0, 5'b0, 1'b0, 17'h0, "R10 clear all");
      rd_sts("R10 status zero");
      op(6'b100001, 18'h0, 5'b00001, 1'b0, 17'h0, "R13 event after clear");
      rd_sts("R13 done survives clear");
      // R10 then load in one instruction
      op(6'b100101, 18'h00A00, 5'b0, 1'b0, 17'h0, "R10 clear then load");
      rd_sts("R10 load after clear");
      // R11 loads
      op(6'b000100, 18'h2A5A5, 5'b0, 1'b0, 17'h0, "R11 load da");
      op(6'b010100, 18'h3BEEF, 5'b0, 1'b0, 17'h0, "R11 load wc");
      op(6'b100010, 18'h37777, 5'b0, 1'b0, 17'h0, "R11 load ma");
      // R12: busy set while transfer active -> no start
      op(6'b100001, 18'h0, 5'b0, 1'b0, 17'h0, "R10 clear");
      op(6'b100100, 18'h00400, 5'b0, 1'b1, 17'h0, "R12 busy while active");
      // R3: read disk address
      op(6'b000010, 18'h0, 5'b0, 1'b0, 17'h19875, "R3 read da");
      op(6'b000010, 18'h20000, 5'b0, 1'b0, 17'h00012, "R3 read da OR");
      // R2: random stream
      for (int i = 0; i < 4000; i++) begin
         logic [5:0]  p;
         logic [4:0]  ev;
         p  = 6'($urandom);
         ev = 5'(($urandom % 8 == 0) ? (1 << ($urandom % 5)) : 0);
         op(p, 18'($urandom), ev, 1'($urandom), 17'($urandom), "R2 random");
         if (i % 4 == 0) rd_sts("R5 random status read");
      end
      @(negedge clk);
      iot_valid = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule